// File: doc/BRIEF.md
# Synchronous FIFO with parameter-set fill flags

A single-clock first-in first-out buffer. The data width and the depth are set by parameters. The depth is given as a word count and need not be a power of two. The address width is derived from it internally, and both pointers wrap from the last slot back to slot zero.

Alongside the usual full and empty outputs, the block provides:
- a live occupancy count;
- a bank of fill-level flags, where the number of flags and the level at which each trips are fixed by parameters.

A parameter chooses how the read data is presented:
- In fall-through mode the oldest stored word already sits on the output whenever the buffer holds data, so a read request only acknowledges it.
- In registered mode a word reaches the output on the clock edge that accepts a read request.

Two clears are provided. The active-low asynchronous reset clears everything except the storage array. A synchronous clear input empties the buffer by returning the pointers, the count and the flags to zero. It leaves the storage array and the output word untouched.

Top module: `flag_fifo`

## Requirements
- R1: While rst_ni is low, and after it is released with no request, empty_o=1, full_o=0, count_o=0, all level_o bits are 0 and rdata_o=0.
- R2: A write request is accepted when the buffer is not full, or when a read is accepted in the same cycle. wdata_i is captured on the edge at which wr_req_i is sampled high, and count_o rises by one after that edge if no read is accepted.
- R3: Words leave in the order they were accepted. This holds across any number of pointer wraps, including with a depth that is not a power of two (default depth 12).
- R4: With RD_MODE=RD_FALL_THROUGH (enum value 1), rdata_o shows the oldest stored word from the edge that stores it into an empty buffer onward. After each accepted read, the next word shows from that edge, with no further request.
- R5: With RD_MODE=RD_REGISTERED (enum value 0), rdata_o changes only on an edge at which a read is accepted, and then takes the word being removed.
- R6: A write and a read requested together on a non-empty buffer are both accepted and count_o stays the same. This also holds when the buffer is full.
- R7: A write request while full with no read request is ignored: count_o stays at DEPTH and the stored sequence is unchanged.
- R8: A read request while empty is ignored: count_o stays 0 and rdata_o is unchanged. A write requested in the same cycle is still accepted.
- R9: count_o ranges from 0 to DEPTH. full_o is 1 exactly when count_o equals DEPTH, and empty_o is 1 exactly when count_o equals 0.
- R10: level_o[i] is 1 exactly when count_o >= the level held in bits [32*i+31:32*i] of FLAG_LEVELS. Each flag is registered and changes on the same edge as count_o. Levels lie in 1..DEPTH; the defaults are 6, 9 and 11.
- R11: clr_i high empties the buffer after the next edge: count_o=0, empty_o=1, all flags 0, and rdata_o unchanged. It takes priority over write and read requests in the same cycle, and the words written afterwards come out correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of pointers, count and flags |
| wr_req_i | input | 1 | Write request |
| wdata_i | input | DATA_W | Write data |
| rd_req_i | input | 1 | Read request |
| rdata_o | output | DATA_W | Read data |
| count_o | output | clog2(DEPTH+1) | Number of stored words |
| full_o | output | 1 | Buffer holds DEPTH words |
| empty_o | output | 1 | Buffer holds no word |
| level_o | output | N_FLAGS | Fill-level flags |

## Verification
The assertions assume that every input is driven to a known value once reset is released. They also assume that each entry of FLAG_LEVELS lies between 1 and DEPTH; a level of zero would make a flag disagree with its reset value. Requests may otherwise arrive in any combination, including a clear together with a write and a read, and the properties cover those overlaps. The stimulus changes all inputs only on the falling clock edge, never leaves them undefined, and uses the default levels 6, 9 and 11 with a depth of 12.

// File: rtl/flag_fifo_pkg.sv
package flag_fifo_pkg;

  typedef enum logic {
    RD_REGISTERED   = 1'b0,
    RD_FALL_THROUGH = 1'b1
  } rd_mode_e;

  function automatic int unsigned addr_width(int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

  function automatic int unsigned count_width(int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/flag_fifo_ctrl.sv
module flag_fifo_ctrl
  import flag_fifo_pkg::*;
#(
  parameter int unsigned DEPTH   = 12,
  parameter int unsigned AW      = 4,
  parameter int unsigned CW      = 4,
  parameter rd_mode_e    RD_MODE = RD_FALL_THROUGH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          load_o,
  output logic          bypass_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          full_o,
  output logic          empty_o
);

  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q, rd_ptr_inc, wr_ptr_inc;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_en, wr_en;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == CNT_MAX);
  assign empty_o = (cnt_q == '0);

  assign rd_en = rd_req_i & ~empty_o & ~clr_i;
  // a read frees the slot, so a full buffer still takes a paired write
  assign wr_en = wr_req_i & (~full_o | rd_en) & ~clr_i;

  assign rd_ptr_inc = ptr_inc(rd_ptr_q);
  assign wr_ptr_inc = ptr_inc(wr_ptr_q);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      unique case ({wr_en, rd_en})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (clr_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (wr_en) wr_ptr_q <= wr_ptr_inc;
        if (rd_en) rd_ptr_q <= rd_ptr_inc;
      end
    end
  end

  generate
    if (RD_MODE == RD_FALL_THROUGH) begin : g_fwft
      logic [CW-1:0] remain;
      // words left from before this edge once the read is taken
      assign remain    = cnt_q - CW'(rd_en);
      assign load_o    = ~clr_i & ((remain != '0) | wr_en);
      assign bypass_o  = (remain == '0);
      assign rd_addr_o = rd_en ? rd_ptr_inc : rd_ptr_q;
    end else begin : g_reg
      assign load_o    = rd_en;
      assign bypass_o  = 1'b0;
      assign rd_addr_o = rd_ptr_q;
    end
  endgenerate

  assign wr_en_o   = wr_en;
  assign wr_addr_o = wr_ptr_q;
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R9
  AST_FULL_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_req_i && !rd_req_i && !clr_i |=> full_o && $stable(wr_ptr_q)); // R7
  AST_PAIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && rd_req_i && !empty_o && !clr_i |=> $stable(cnt_q)); // R6
  AST_EMPTY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_req_i && !wr_req_i && !clr_i |=> empty_o && $stable(rd_ptr_q)); // R8
  AST_CLR_PTRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o && (rd_ptr_q == '0) && (wr_ptr_q == '0)); // R11
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr_q <= LAST) && (rd_ptr_q <= LAST)); // R3

endmodule

// File: rtl/flag_fifo_mem.sv
module flag_fifo_mem #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 12,
  parameter int unsigned AW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          load_i,
  input  logic          bypass_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  // storage has no reset; neither clear touches it
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (load_i) begin
      rdata_q <= bypass_i ? wdata_i : mem_q[rd_addr_i];
    end
  end

  assign rdata_o = rdata_q;

  AST_BYPASS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && bypass_i |-> wr_en_i); // R4

endmodule

// File: rtl/flag_fifo_thresh.sv
module flag_fifo_thresh #(
  parameter int unsigned           N_FLAGS     = 3,
  parameter int unsigned           CW          = 4,
  parameter logic [N_FLAGS*32-1:0] FLAG_LEVELS = {32'd11, 32'd9, 32'd6}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CW-1:0]      cnt_nxt_i,
  input  logic [CW-1:0]      cnt_i,
  output logic [N_FLAGS-1:0] level_o
);

  logic [N_FLAGS-1:0] level_q;

  generate
    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
      localparam logic [CW-1:0] LVL = CW'(FLAG_LEVELS[32*i +: 32]);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) level_q[i] <= 1'b0;
        else         level_q[i] <= (cnt_nxt_i >= LVL);
      end

      AST_FLAG_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_q[i] == (cnt_i >= LVL)); // R10
    end
  endgenerate

  assign level_o = level_q;

endmodule

// File: rtl/flag_fifo.sv
module flag_fifo
  import flag_fifo_pkg::*;
#(
  parameter int unsigned           DATA_W      = 8,
  parameter int unsigned           DEPTH       = 12,
  parameter int unsigned           N_FLAGS     = 3,
  parameter logic [N_FLAGS*32-1:0] FLAG_LEVELS = {32'd11, 32'd9, 32'd6},
  parameter rd_mode_e              RD_MODE     = RD_FALL_THROUGH,
  localparam int unsigned          AW          = addr_width(DEPTH),
  localparam int unsigned          CW          = count_width(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_req_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               rd_req_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [CW-1:0]      count_o,
  output logic               full_o,
  output logic               empty_o,
  output logic [N_FLAGS-1:0] level_o
);

  logic          wr_en, load, bypass;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] cnt, cnt_nxt;

  flag_fifo_ctrl #(
    .DEPTH   (DEPTH),
    .AW      (AW),
    .CW      (CW),
    .RD_MODE (RD_MODE)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .wr_req_i  (wr_req_i),
    .rd_req_i  (rd_req_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr),
    .load_o    (load),
    .bypass_o  (bypass),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .full_o    (full_o),
    .empty_o   (empty_o)
  );

  flag_fifo_mem #(
    .DW    (DATA_W),
    .DEPTH (DEPTH),
    .AW    (AW)
  ) i_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wdata_i   (wdata_i),
    .rd_addr_i (rd_addr),
    .load_i    (load),
    .bypass_i  (bypass),
    .rdata_o   (rdata_o)
  );

  flag_fifo_thresh #(
    .N_FLAGS     (N_FLAGS),
    .CW          (CW),
    .FLAG_LEVELS (FLAG_LEVELS)
  ) i_thresh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_nxt_i (cnt_nxt),
    .cnt_i     (cnt),
    .level_o   (level_o)
  );

  assign count_o = cnt;

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R9
  AST_CLR_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> $stable(rdata_o) && (level_o == '0)); // R11

  generate
    if (RD_MODE == RD_FALL_THROUGH) begin : g_fwft_chk
      AST_EMPTY_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty_o && !wr_req_i |=> $stable(rdata_o)); // R8
      AST_FWFT_SHOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty_o && wr_req_i && !clr_i |=> rdata_o == $past(wdata_i)); // R4
    end else begin : g_reg_chk
      AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_req_i |=> $stable(rdata_o)); // R5
    end
  endgenerate

endmodule

// File: tb/test_flag_fifo.sv
`timescale 1ns/1ps
module test_flag_fifo;
  import flag_fifo_pkg::*;

  localparam int DW    = 8;
  localparam int DEPTH = 12;
  localparam int NF    = 3;
  localparam int CW    = 4;
  localparam int LVL [NF] = '{6, 9, 11};

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata_f, rdata_r;
  logic [CW-1:0] cnt_f, cnt_r;
  logic          full_f, full_r, empty_f, empty_r;
  logic [NF-1:0] lvl_f, lvl_r;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] q [$];
  logic [DW-1:0] exp_f = '0, exp_r = '0;
  logic [DW-1:0] seed = 8'h10;

  always #2 clk = ~clk;

  flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .N_FLAGS(NF), .RD_MODE(RD_FALL_THROUGH)) i_flag_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .wr_req_i(wr), .wdata_i(wdata),
    .rd_req_i(rd), .rdata_o(rdata_f), .count_o(cnt_f), .full_o(full_f),
    .empty_o(empty_f), .level_o(lvl_f));

  flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .N_FLAGS(NF), .RD_MODE(RD_REGISTERED)) i_flag_fifo_reg (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .wr_req_i(wr), .wdata_i(wdata),
    .rd_req_i(rd), .rdata_o(rdata_r), .count_o(cnt_r), .full_o(full_r),
    .empty_o(empty_r), .level_o(lvl_r));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NF-1:0] exp_lvl(int c);
    logic [NF-1:0] r;
    for (int i = 0; i < NF; i++) r[i] = (c >= LVL[i]);
    return r;
  endfunction

  task automatic check_outs(string req);
    int c = q.size();
    chk(req, "count fwft", 32'(cnt_f), 32'(c));
    chk(req, "count reg", 32'(cnt_r), 32'(c));
    chk(req, "full fwft", 32'(full_f), 32'(c == DEPTH));
    chk(req, "full reg", 32'(full_r), 32'(c == DEPTH));
    chk(req, "empty fwft", 32'(empty_f), 32'(c == 0));
    chk(req, "empty reg", 32'(empty_r), 32'(c == 0));
    chk(req, "levels fwft", 32'(lvl_f), 32'(exp_lvl(c)));
    chk(req, "levels reg", 32'(lvl_r), 32'(exp_lvl(c)));
    chk(req, "rdata fwft", 32'(rdata_f), 32'(exp_f));
    chk(req, "rdata reg", 32'(rdata_r), 32'(exp_r));
  endtask

  // one clock: drive at falling edge, model at rising edge, check at next falling edge
  task automatic cyc(string req, logic w, logic r, logic c, logic [DW-1:0] d);
    bit rdok, wrok;
    wr = w; rd = r; clr = c; wdata = d;
    @(posedge clk);
    if (c) begin
      q.delete();
    end else begin
      rdok = r && (q.size() > 0);
      wrok = w && ((q.size() < DEPTH) || rdok);
      if (rdok) exp_r = q.pop_front();
      if (wrok) q.push_back(d);
      if (q.size() > 0) exp_f = q[0];
    end
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; clr = 1'b0;
    check_outs(req);
  endtask

  function automatic logic [DW-1:0] next_word();
    seed = seed + 8'h0b;
    return seed;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check_outs("R1");
    rst_ni = 1'b1;
    cyc("R1", 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_read_modes();
    cyc("R4", 1'b1, 1'b0, 1'b0, 8'hA5);
    cyc("R5", 1'b0, 1'b0, 1'b0, 8'h00);
    cyc("R4", 1'b1, 1'b0, 1'b0, 8'h3C);
    cyc("R5", 1'b0, 1'b1, 1'b0, 8'h00);
    cyc("R4", 1'b0, 1'b1, 1'b0, 8'h00);
    cyc("R5", 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) cyc("R10", 1'b1, 1'b0, 1'b0, next_word());
    chk("R9", "full at depth", 32'(full_f & full_r), 32'd1);
  endtask

  task automatic t_overflow();
    cyc("R7", 1'b1, 1'b0, 1'b0, 8'hEE);
    cyc("R7", 1'b1, 1'b0, 1'b0, 8'hDD);
    for (int i = 0; i < DEPTH; i++) cyc("R3", 1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_underflow();
    cyc("R8", 1'b0, 1'b1, 1'b0, 8'h00);
    cyc("R8", 1'b0, 1'b1, 1'b0, 8'h00);
    cyc("R8", 1'b1, 1'b1, 1'b0, 8'h77);
    cyc("R8", 1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_simul();
    for (int i = 0; i < 5; i++) cyc("R2", 1'b1, 1'b0, 1'b0, next_word());
    for (int i = 0; i < 8; i++) cyc("R6", 1'b1, 1'b1, 1'b0, next_word());
    for (int i = 0; i < DEPTH - 5; i++) cyc("R2", 1'b1, 1'b0, 1'b0, next_word());
    for (int i = 0; i < 3; i++) cyc("R6", 1'b1, 1'b1, 1'b0, next_word());
    for (int i = 0; i < DEPTH; i++) cyc("R3", 1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 60; i++)
      cyc("R3", (i % 3) != 2, (i % 2) == 0, 1'b0, next_word());
    while (q.size() > 0) cyc("R3", 1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_clear();
    for (int i = 0; i < 10; i++) cyc("R10", 1'b1, 1'b0, 1'b0, next_word());
    cyc("R11", 1'b1, 1'b1, 1'b1, 8'h99);
    cyc("R11", 1'b0, 1'b1, 1'b0, 8'h00);
    cyc("R11", 1'b1, 1'b0, 1'b0, 8'h42);
    cyc("R11", 1'b1, 1'b0, 1'b0, 8'h43);
    cyc("R11", 1'b0, 1'b1, 1'b0, 8'h00);
    cyc("R11", 1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  initial begin
    t_reset();
    t_read_modes();
    t_fill();
    t_overflow();
    t_underflow();
    t_simul();
    t_wrap();
    t_clear();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule